// File: doc/BRIEF.md
# Multichannel Gain Register Controller

This block gives a host a small 16-bit register window for setting and reading back the gain codes of 32 amplifier channels. The host selects a channel in the channel-select register, then either writes a gain code to the code register, requests a readback of the selected channel, or triggers a broadcast clear that drops every channel to the lowest gain. Each command is carried to the channel latches over an internal serial link. The latch bank is modelled inside the block and its 32 codes are visible on an internal bus.

A single busy flag in the channel-select register guards the link. The flag is set by every accepted command. For a readback, the host sets the flag directly. It clears when the serial exchange has finished. While the flag is set, the block drops every host write. A serial frame carries, most significant bit first, a broadcast flag, a read flag, the 5-bit channel number and the 4-bit code. One bit is shifted every four system clocks. A readback frame is followed by four returned code bits.

Top module: `gain_link_ctrl`

## Requirements
- R1: After reset the channel-select register reads 0 with busy clear, the code register reads 0, and every channel holds code 0.
- R2: The channel-select register is at byte offset 0. Bits 4:0 hold the channel (0 to 31) and bit 15 reads back busy. Bits 14:5 are ignored on write and read as 0. A write with bit 15 clear only changes the channel and leaves busy clear.
- R3: Any write to offset 0, 2 or 4 that arrives while busy is set changes neither the selected channel, nor the code register, nor any channel code.
- R4: A write to offset 2 (code in bits 3:0) while busy is clear sets busy from the next cycle on. Busy clears within 64 cycles, and the selected channel then holds the code.
- R5: A code above 12 written to offset 2 is clamped to 12. The code register reads back the clamped value, and the clamped value is what reaches the channel.
- R6: Writing offset 0 with bit 15 set while busy is clear selects the channel in bits 4:0 and starts a readback. When busy clears, the code register at offset 2 holds that channel's current code.
- R7: A write of any value to offset 4 while busy is clear sets busy. When busy clears, all 32 channels hold code 0.
- R8: A code write changes only the selected channel and leaves the other 31 unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 3 | Register byte offset (0, 2 or 4) |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read enable; read data is 0 when low |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for the addressed register |

## Verification
The bench targets the interlock window. It issues channel, code and broadcast writes while a transfer is in flight. A design that leaked one of them would move the selection, overwrite the code register, or corrupt a neighbouring channel, and the later readbacks expose each of these.

Every channel is written with a code pattern that includes values from 13 to 15. A missing clamp or a wrong frame bit order therefore shows up as wrong readback values. The readback sweep checks that the returned bits are assembled in the right order for every channel. The broadcast test checks that all channels are cleared, not just the selected one.

// File: rtl/gain_link_pkg.sv
package gain_link_pkg;
  localparam int NUM_CH   = 32;
  localparam int CH_W     = $clog2(NUM_CH);
  localparam int CODE_W   = 4;
  localparam int CODE_MAX = 12;
  localparam int DATA_W   = 16;
  localparam int ADDR_W   = 3;
  localparam int DIV      = 4;
  localparam int FRAME_W  = 2 + CH_W + CODE_W;
  localparam int XFER_MAX = FRAME_W + CODE_W;

  localparam logic [ADDR_W-1:0] OFS_CHSEL = 3'd0;
  localparam logic [ADDR_W-1:0] OFS_CODE  = 3'd2;
  localparam logic [ADDR_W-1:0] OFS_CLEAR = 3'd4;

  typedef struct packed {
    logic              bcast;
    logic              rd;
    logic [CH_W-1:0]   ch;
    logic [CODE_W-1:0] code;
  } frame_t;

  function automatic logic [CODE_W-1:0] clamp_code(input logic [CODE_W-1:0] c);
    return (c > CODE_W'(CODE_MAX)) ? CODE_W'(CODE_MAX) : c;
  endfunction
endpackage

// File: rtl/gain_host_regs.sv
module gain_host_regs
  import gain_link_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              start,
  output frame_t            cmd,
  input  logic              done,
  input  logic [CODE_W-1:0] rd_code,
  output logic              busy,
  output logic [CH_W-1:0]   sel_ch
);
  logic [CH_W-1:0]   ch_q, ch_d;
  logic [CODE_W-1:0] code_q, code_d;
  logic              busy_q, busy_d;
  logic              rdpend_q, rdpend_d;
  logic              accept;
  logic [CODE_W-1:0] clamped;
  logic              wdata_unused;

  assign wdata_unused = ^bus_wdata[DATA_W-2:CH_W];
  assign accept  = bus_wr && !busy_q;
  assign clamped = clamp_code(bus_wdata[CODE_W-1:0]);

  always_comb begin
    ch_d     = ch_q;
    code_d   = code_q;
    busy_d   = busy_q;
    rdpend_d = rdpend_q;
    start    = 1'b0;
    cmd      = '0;
    if (done) begin
      busy_d   = 1'b0;
      rdpend_d = 1'b0;
      if (rdpend_q) code_d = rd_code;
    end
    if (accept) begin
      unique case (bus_addr)
        OFS_CHSEL: begin
          ch_d = bus_wdata[CH_W-1:0];
          if (bus_wdata[DATA_W-1]) begin
            busy_d   = 1'b1;
            rdpend_d = 1'b1;
            start    = 1'b1;
            cmd      = '{bcast: 1'b0, rd: 1'b1, ch: bus_wdata[CH_W-1:0], code: '0};
          end
        end
        OFS_CODE: begin
          code_d = clamped;
          busy_d = 1'b1;
          start  = 1'b1;
          cmd    = '{bcast: 1'b0, rd: 1'b0, ch: ch_q, code: clamped};
        end
        OFS_CLEAR: begin
          busy_d = 1'b1;
          start  = 1'b1;
          cmd    = '{bcast: 1'b1, rd: 1'b0, ch: '0, code: '0};
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ch_q     <= '0;
      code_q   <= '0;
      busy_q   <= 1'b0;
      rdpend_q <= 1'b0;
    end else begin
      ch_q     <= ch_d;
      code_q   <= code_d;
      busy_q   <= busy_d;
      rdpend_q <= rdpend_d;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      unique case (bus_addr)
        OFS_CHSEL: bus_rdata = {busy_q, {(DATA_W-1-CH_W){1'b0}}, ch_q};
        OFS_CODE:  bus_rdata = {{(DATA_W-CODE_W){1'b0}}, code_q};
        default:   bus_rdata = '0;
      endcase
    end
  end

  assign busy   = busy_q;
  assign sel_ch = ch_q;
endmodule

// File: rtl/gain_serial_tx.sv
module gain_serial_tx
  import gain_link_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  frame_t            cmd,
  output logic              link_sel,
  output logic              link_bit,
  output logic              link_stb,
  input  logic              link_ret,
  output logic              done,
  output logic [CODE_W-1:0] rd_code
);
  localparam int DIV_W = $clog2(DIV);
  localparam int CNT_W = $clog2(XFER_MAX + 1);

  logic               active_q, active_d;
  logic [FRAME_W-1:0] shift_q, shift_d;
  logic [DIV_W-1:0]   div_q, div_d;
  logic [CNT_W-1:0]   bit_q, bit_d;
  logic [CNT_W-1:0]   last_q, last_d;
  logic [CODE_W-2:0]  ret_q, ret_d;

  assign link_stb = active_q && (div_q == DIV_W'(DIV - 1));
  assign done     = link_stb && (bit_q == last_q);
  assign link_sel = active_q;
  assign link_bit = shift_q[FRAME_W-1];
  assign rd_code  = {ret_q, link_ret};

  always_comb begin
    active_d = active_q;
    shift_d  = shift_q;
    div_d    = div_q;
    bit_d    = bit_q;
    last_d   = last_q;
    ret_d    = ret_q;
    if (start) begin
      active_d = 1'b1;
      shift_d  = cmd;
      div_d    = '0;
      bit_d    = '0;
      last_d   = cmd.rd ? CNT_W'(XFER_MAX - 1) : CNT_W'(FRAME_W - 1);
    end else if (active_q) begin
      div_d = div_q + 1'b1;
      if (link_stb) begin
        bit_d   = bit_q + 1'b1;
        shift_d = {shift_q[FRAME_W-2:0], 1'b0};
        if (bit_q >= CNT_W'(FRAME_W)) ret_d = {ret_q[CODE_W-3:0], link_ret};
        if (done) active_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      shift_q  <= '0;
      div_q    <= '0;
      bit_q    <= '0;
      last_q   <= '0;
      ret_q    <= '0;
    end else begin
      active_q <= active_d;
      shift_q  <= shift_d;
      div_q    <= div_d;
      bit_q    <= bit_d;
      last_q   <= last_d;
      ret_q    <= ret_d;
    end
  end
endmodule

// File: rtl/gain_latch_bank.sv
module gain_latch_bank
  import gain_link_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     link_sel,
  input  logic                     link_stb,
  input  logic                     link_bit,
  output logic                     link_ret,
  output logic [NUM_CH*CODE_W-1:0] gain_flat
);
  localparam int CNT_W = $clog2(XFER_MAX + 1);

  logic [FRAME_W-2:0] rx_q, rx_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic [CODE_W-1:0]  ret_q, ret_d;
  logic [CODE_W-1:0]  codes_q [NUM_CH];
  logic [CODE_W-1:0]  codes_d [NUM_CH];
  frame_t             full;

  assign full     = frame_t'({rx_q, link_bit});
  assign link_ret = ret_q[CODE_W-1];

  always_comb begin
    rx_d  = rx_q;
    cnt_d = cnt_q;
    ret_d = ret_q;
    for (int i = 0; i < NUM_CH; i++) codes_d[i] = codes_q[i];
    if (!link_sel) begin
      cnt_d = '0;
    end else if (link_stb) begin
      cnt_d = cnt_q + 1'b1;
      if (cnt_q < CNT_W'(FRAME_W - 1)) begin
        rx_d = {rx_q[FRAME_W-3:0], link_bit};
      end else if (cnt_q == CNT_W'(FRAME_W - 1)) begin
        if (full.bcast) begin
          for (int i = 0; i < NUM_CH; i++) codes_d[i] = '0;
        end else if (full.rd) begin
          ret_d = codes_q[full.ch];
        end else begin
          codes_d[full.ch] = full.code;
        end
      end else begin
        ret_d = {ret_q[CODE_W-2:0], 1'b0};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_q  <= '0;
      cnt_q <= '0;
      ret_q <= '0;
      for (int i = 0; i < NUM_CH; i++) codes_q[i] <= '0;
    end else begin
      rx_q  <= rx_d;
      cnt_q <= cnt_d;
      ret_q <= ret_d;
      for (int i = 0; i < NUM_CH; i++) codes_q[i] <= codes_d[i];
    end
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : g_flat
    assign gain_flat[g*CODE_W +: CODE_W] = codes_q[g];
  end
endmodule

// File: rtl/gain_link_ctrl.sv
module gain_link_ctrl
  import gain_link_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata
);
  logic                     start, done, busy;
  frame_t                   cmd;
  logic [CODE_W-1:0]        rd_code;
  logic [CH_W-1:0]          sel_ch;
  logic                     link_sel, link_bit, link_stb, link_ret;
  logic [NUM_CH*CODE_W-1:0] gain_flat;

  gain_host_regs u_regs (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .start(start), .cmd(cmd), .done(done), .rd_code(rd_code),
    .busy(busy), .sel_ch(sel_ch)
  );

  gain_serial_tx u_tx (
    .clk(clk), .rst_n(rst_n), .start(start), .cmd(cmd),
    .link_sel(link_sel), .link_bit(link_bit), .link_stb(link_stb),
    .link_ret(link_ret), .done(done), .rd_code(rd_code)
  );

  gain_latch_bank u_bank (
    .clk(clk), .rst_n(rst_n), .link_sel(link_sel), .link_stb(link_stb),
    .link_bit(link_bit), .link_ret(link_ret), .gain_flat(gain_flat)
  );
endmodule

// File: rtl/gain_link_chk.sv
module gain_link_chk
  import gain_link_pkg::*;
(
  input logic                     clk,
  input logic                     rst_n,
  input logic                     bus_wr,
  input logic                     busy,
  input logic [CH_W-1:0]          sel_ch,
  input logic                     start,
  input frame_t                   cmd,
  input logic                     done,
  input logic                     link_sel,
  input logic [NUM_CH*CODE_W-1:0] gain_flat
);
  logic bcast_pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     bcast_pend <= 1'b0;
    else if (start) bcast_pend <= cmd.bcast;
  end

  a_r3_sel_held: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && bus_wr) |=> $stable(sel_ch));

  a_r3_flat_held_no_link: assert property (@(posedge clk) disable iff (!rst_n)
    !link_sel |=> $stable(gain_flat));

  a_r4_busy_after_start: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy);

  a_r4_link_only_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
    link_sel |-> busy);

  a_r4_done_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy);

  a_r5_code_clamped: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> (cmd.code <= CODE_W'(CODE_MAX)));

  a_r7_bcast_clears_all: assert property (@(posedge clk) disable iff (!rst_n)
    (done && bcast_pend) |=> (gain_flat == '0));
endmodule

bind gain_link_ctrl gain_link_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .busy(busy), .sel_ch(sel_ch),
  .start(start), .cmd(cmd), .done(done), .link_sel(link_sel),
  .gain_flat(gain_flat)
);

// File: tb/test_gain_link_ctrl.sv
module test_gain_link_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 32;

  logic        clk;
  logic        rst_n;
  logic [2:0]  bus_addr;
  logic        bus_wr, bus_rd;
  logic [15:0] bus_wdata;
  logic [15:0] bus_rdata;

  int checks = 0;
  int errors = 0;
  logic [3:0] exp_code [NCH];

  gain_link_ctrl i_gain_link_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    bus_rd = 1'b0;
  endtask

  task automatic wait_idle(input string req, output int cyc);
    logic [15:0] v;
    cyc = 0;
    rd(3'd0, v);
    while (v[15] && cyc < 200) begin
      @(negedge clk);
      cyc++;
      rd(3'd0, v);
    end
    checks++;
    if (cyc > 64) begin
      errors++;
      $display("FAIL %s: busy held actual=%0d cycles expected<=64", req, cyc);
    end
  endtask

  function automatic logic [3:0] clampc(input int c);
    return (c > 12) ? 4'd12 : 4'(c);
  endfunction

  task automatic readback(input string req, input int ch, input logic [3:0] exp);
    logic [15:0] v;
    int cyc;
    wr(3'd0, 16'h8000 | 16'(ch));
    rd(3'd0, v);
    check(req, {15'd0, v[15]}, 16'd1);
    wait_idle(req, cyc);
    rd(3'd0, v);
    check(req, v, 16'(ch));
    rd(3'd2, v);
    check(req, v, {12'd0, exp});
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    logic [15:0] v;
    int cyc;
    bus_addr = '0; bus_wr = 1'b0; bus_rd = 1'b0; bus_wdata = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(3'd0, v); check("R1 chsel", v, 16'h0000);
    rd(3'd2, v); check("R1 code", v, 16'h0000);
    readback("R1 channel 7 zero", 7, 4'd0);
    readback("R1 channel 31 zero", 31, 4'd0);

    // R2 extra bits ignored, busy stays clear
    wr(3'd0, 16'h7FE5);
    rd(3'd0, v); check("R2 ignored bits", v, 16'h0005);

    // R4 R5 R8 write every channel
    for (int ch = 0; ch < NCH; ch++) begin
      int c;
      c = (ch * 7 + 5) % 16;
      wr(3'd0, 16'(ch));
      rd(3'd0, v); check("R2 select", v, 16'(ch));
      wr(3'd2, 16'hFFF0 | 16'(c));
      rd(3'd0, v); check("R4 busy set", v, 16'h8000 | 16'(ch));
      wait_idle("R4 busy clears", cyc);
      rd(3'd2, v); check("R5 code clamped", v, {12'd0, clampc(c)});
      exp_code[ch] = clampc(c);
    end

    // R6 R8 read every channel back
    for (int ch = 0; ch < NCH; ch++) readback("R6 R8 readback", ch, exp_code[ch]);

    // R3 writes while busy dropped
    wr(3'd0, 16'd3);
    wr(3'd2, 16'd9);
    exp_code[3] = 4'd9;
    wr(3'd0, 16'h0011);
    wr(3'd2, 16'h0002);
    wr(3'd4, 16'h0000);
    wait_idle("R3 busy", cyc);
    rd(3'd0, v); check("R3 selection kept", v, 16'd3);
    rd(3'd2, v); check("R3 code kept", v, 16'd9);
    readback("R3 other channel intact", 17, exp_code[17]);
    readback("R3 target written once", 3, 4'd9);

    // R7 broadcast clear
    wr(3'd4, 16'hBEEF);
    rd(3'd0, v); check("R7 busy set", {15'd0, v[15]}, 16'd1);
    wait_idle("R7 busy clears", cyc);
    for (int ch = 0; ch < NCH; ch++) readback("R7 channel cleared", ch, 4'd0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule